// File: doc/BRIEF.md
# Composite 64 kHz Timing Signal Decoder

This block takes a 64 kbit/s composite timing line that has already been sliced into a positive-mark strobe and a negative-mark strobe. Both strobes are qualified by a one-cycle bit-slot strobe. The line is alternate-mark coded with a mark in every slot. Once per eight slots, a code-rule violation repeats the polarity of the mark before it, and these violations carry the 8 kHz frame timing. In the optional three-tier mode, the violation is left out of one frame in every twenty, and that gap carries the 400 Hz timing.

The block hunts for and locks onto both framing levels. It drives an 8 kHz and a 400 Hz square wave whose rising edges follow the violation slot and the omission frame. It also produces a one-cycle missing-mark strobe and a separate out-of-sync flag for each framing level. The slot strobe acts as the valid of the incoming stream. A line cannot be stalled, so there is no ready: every cycle in which `slot_valid` is high is consumed, and the spacing between slot strobes is free. All outputs are plain status pins.

Top module: `c64_clock_decoder`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, drives both out-of-sync flags high and both clock outputs and `miss_o` low from the next cycle.
- R2: A slot strobe with neither mark strobe high raises `miss_o` for exactly the following cycle. A slot that carries a mark leaves it low.
- R3: A violation is a mark with the same polarity as the previous mark; a positive strobe wins when both strobes are high. A violation is valid when it is the first one after reset or when its polarity is opposite to the previous violation. A same-polarity violation does not count towards lock.
- R4: While hunting, the 8 kHz level declares lock (`oos8k_o` low) on the second of two valid violations that are exactly 8 slots apart, in the cycle after that slot.
- R5: While 8 kHz-locked, `clk8k_o` is high for the 4 slots that start with the violation slot and low for the next 4. It rises in the cycle after the violation's slot strobe and stays low while out of sync.
- R6: A locked 8 kHz level stays locked over one expected slot without a valid violation. It drops lock after two such expected slots in a row.
- R7: With `mode_400` low, `oos400_o` stays high and `clk400_o` stays low.
- R8: With `mode_400` high and the 8 kHz level locked, the 400 Hz level locks on the second of two frames without a valid violation that are exactly 20 frames apart.
- R9: While 400 Hz-locked, `clk400_o` is high for the 10 frames that start with the omission frame and low for the next 10.
- R10: When a locked 400 Hz level sees a violation in an expected omission frame, `oos400_o` goes high. It clears at the next expected omission that is present, and lock is lost after two such failures in a row.
- R11: Loss of 8 kHz lock drops 400 Hz lock, and `oos400_o` is high one cycle later.
- R12: `oos8k_o` and `clk8k_o` change only in the cycle after a slot strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_valid | input | 1 | One-cycle bit-slot strobe, the valid of the line stream |
| mark_p | input | 1 | Positive mark in this slot |
| mark_n | input | 1 | Negative mark in this slot |
| mode_400 | input | 1 | 1: decode the 400 Hz tier as well; 0: 64 + 8 kHz only |
| clk8k_o | output | 1 | Recovered 8 kHz square wave |
| clk400_o | output | 1 | Recovered 400 Hz square wave |
| miss_o | output | 1 | One-cycle strobe after a slot with no mark |
| oos8k_o | output | 1 | 8 kHz framing out of sync |
| oos400_o | output | 1 | 400 Hz framing out of sync or expected omission absent |

## Verification
The assertions watch, on every cycle, the properties that hold locally in time. These are the reset values, that a missing-mark strobe follows an empty slot, that 8 kHz state moves only after a slot strobe, that lock is taken only on a slot, that the 400 Hz tier is held off in the two-tier mode, and that it cannot stay locked without 8 kHz lock. Lock spacing, the exact duty pattern of the two square waves, rejection of a same-polarity violation, and the tolerance to a single missed violation or omission are sequence properties. Only the bench's long frame scenarios show them.

// File: rtl/c64_decoder_pkg.sv
package c64_decoder_pkg;

  localparam int unsigned SLOTS_PER_FRAME  = 8;
  localparam int unsigned FRAMES_PER_SUPER = 20;
  localparam int unsigned LOSS_LIMIT       = 2;

  // Per-slot result of the mark decoder
  typedef struct packed {
    logic slot;     // slot strobe this cycle
    logic viol_ok;  // valid framing violation in this slot
  } slot_evt_t;

endpackage

// File: rtl/c64_mark_decoder.sv
module c64_mark_decoder
  import c64_decoder_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      slot_valid,
  input  logic      mark_p,
  input  logic      mark_n,
  output slot_evt_t evt_o,
  output logic      miss_o
);

  logic have_mark, last_pol;
  logic have_viol, viol_pol;
  logic mark, pol, is_viol;

  always_comb begin
    mark    = mark_p | mark_n;
    pol     = mark_p;  // positive wins when both are high
    is_viol = slot_valid && mark && have_mark && (pol == last_pol);
    evt_o.slot    = slot_valid;
    evt_o.viol_ok = is_viol && (!have_viol || (pol != viol_pol));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_mark <= 1'b0;
      last_pol  <= 1'b0;
      have_viol <= 1'b0;
      viol_pol  <= 1'b0;
      miss_o    <= 1'b0;
    end else begin
      miss_o <= slot_valid && !mark;
      if (slot_valid && mark) begin
        have_mark <= 1'b1;
        last_pol  <= pol;
      end
      if (is_viol) begin
        have_viol <= 1'b1;
        viol_pol  <= pol;
      end
    end
  end

endmodule

// File: rtl/c64_period_lock.sv
module c64_period_lock #(
  parameter int unsigned PERIOD = 8,
  parameter int unsigned LOSS   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  input  logic hit,
  output logic locked_o,
  output logic boundary_o,
  output logic square_o,
  output logic fail_o
);

  localparam int unsigned CW   = $clog2(PERIOD) + 1;
  localparam int unsigned FW   = $clog2(LOSS + 1);
  localparam int unsigned HALF = PERIOD / 2;
  localparam logic [CW-1:0] HUNT = '1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;
  logic [FW-1:0] fail;
  logic          locked;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      locked <= 1'b0;
      cnt    <= HUNT;
      fail   <= '0;
    end else if (tick) begin
      if (!locked) begin
        if (hit) begin
          cnt <= '0;
          if (cnt == LAST) locked <= 1'b1;
        end else if (cnt != HUNT) begin
          cnt <= cnt + 1'b1;
        end
      end else if (cnt == LAST) begin
        if (hit) begin
          fail <= '0;
          cnt  <= '0;
        end else if (fail == FW'(LOSS - 1)) begin
          locked <= 1'b0;
          cnt    <= HUNT;
          fail   <= '0;
        end else begin
          fail <= fail + 1'b1;
          cnt  <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign locked_o   = locked;
  assign boundary_o = locked && (cnt == LAST);
  assign square_o   = locked && (cnt < CW'(HALF));
  assign fail_o     = (fail != '0);

endmodule

// File: rtl/c64_clock_decoder.sv
module c64_clock_decoder
  import c64_decoder_pkg::*;
#(
  parameter int unsigned SLOTS  = SLOTS_PER_FRAME,
  parameter int unsigned FRAMES = FRAMES_PER_SUPER,
  parameter int unsigned LOSS   = LOSS_LIMIT
) (
  input  logic clk,
  input  logic rst,
  input  logic slot_valid,
  input  logic mark_p,
  input  logic mark_n,
  input  logic mode_400,
  output logic clk8k_o,
  output logic clk400_o,
  output logic miss_o,
  output logic oos8k_o,
  output logic oos400_o
);

  slot_evt_t evt;
  logic frm_locked, frm_edge, frm_sq, frm_fail_unused;
  logic sup_locked, sup_edge_unused, sup_sq, sup_fail;
  logic sup_tick, sup_hit, sup_clear;

  c64_mark_decoder u_dec (
    .clk        (clk),
    .rst        (rst),
    .slot_valid (slot_valid),
    .mark_p     (mark_p),
    .mark_n     (mark_n),
    .evt_o      (evt),
    .miss_o     (miss_o)
  );

  // 8 kHz level: one opportunity per slot, hit = valid violation
  c64_period_lock #(.PERIOD(SLOTS), .LOSS(LOSS)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .clear      (1'b0),
    .tick       (evt.slot),
    .hit        (evt.viol_ok),
    .locked_o   (frm_locked),
    .boundary_o (frm_edge),
    .square_o   (frm_sq),
    .fail_o     (frm_fail_unused)
  );

  // 400 Hz level: one opportunity per frame boundary, hit = omission
  assign sup_tick  = evt.slot && frm_edge;
  assign sup_hit   = !evt.viol_ok;
  assign sup_clear = !mode_400 || !frm_locked;

  c64_period_lock #(.PERIOD(FRAMES), .LOSS(LOSS)) u_super (
    .clk        (clk),
    .rst        (rst),
    .clear      (sup_clear),
    .tick       (sup_tick),
    .hit        (sup_hit),
    .locked_o   (sup_locked),
    .boundary_o (sup_edge_unused),
    .square_o   (sup_sq),
    .fail_o     (sup_fail)
  );

  assign clk8k_o  = frm_sq;
  assign clk400_o = sup_sq;
  assign oos8k_o  = !frm_locked;
  assign oos400_o = !sup_locked || sup_fail;

endmodule

// File: rtl/c64_clock_decoder_chk.sv
module c64_clock_decoder_chk (
  input logic clk,
  input logic rst,
  input logic slot_valid,
  input logic mark_p,
  input logic mark_n,
  input logic mode_400,
  input logic clk8k_o,
  input logic clk400_o,
  input logic miss_o,
  input logic oos8k_o,
  input logic oos400_o
);

  assert_reset_flags_R1: assert property (@(posedge clk)
    rst |=> (oos8k_o && oos400_o && !clk8k_o && !clk400_o && !miss_o));

  assert_miss_after_empty_R2: assert property (@(posedge clk) disable iff (rst)
    miss_o |-> ($past(slot_valid) && !$past(mark_p) && !$past(mark_n)));

  assert_lock_on_slot_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(oos8k_o) |-> $past(slot_valid));

  assert_two_tier_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !mode_400 |=> (oos400_o && !clk400_o));

  assert_super_needs_frame_R11: assert property (@(posedge clk) disable iff (rst)
    (oos8k_o && $past(oos8k_o)) |-> oos400_o);

  assert_quiet_between_slots_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(slot_valid) |-> ($stable(oos8k_o) && $stable(clk8k_o)));

endmodule

bind c64_clock_decoder c64_clock_decoder_chk u_chk (.*);

// File: tb/c64_clock_decoder_tb.sv
`timescale 1ns/1ps
module c64_clock_decoder_tb;

  logic clk = 1'b0, rst = 1'b1, slot_valid = 1'b0;
  logic mark_p = 1'b0, mark_n = 1'b0, mode_400 = 1'b0;
  logic clk8k_o, clk400_o, miss_o, oos8k_o, oos400_o;

  c64_clock_decoder u_dut (.*);

  always #2.5 clk = ~clk;

  localparam int K_ALT = 0, K_REP = 1, K_NONE = 2;
  // {kind[4:3], exp oos8k[2], exp clk8k[1], exp miss[0]}
  localparam logic [4:0] VEC [25] = '{
    5'b00_100, 5'b01_100,
    5'b00_100, 5'b00_100, 5'b00_100, 5'b00_100, 5'b00_100, 5'b00_100, 5'b00_100,
    5'b01_010, 5'b00_010, 5'b00_010, 5'b00_010,
    5'b00_000, 5'b00_000, 5'b00_000, 5'b00_000,
    5'b01_010, 5'b00_010, 5'b00_010, 5'b10_011,
    5'b00_000, 5'b00_000, 5'b00_000, 5'b00_000 };

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  logic last_pol = 1'b0;
  logic s_miss, s_miss_next, s_oos8, s_clk8, s_oos8_idle, s_clk8_idle;
  logic s_oos400_idle, s_clk400_idle;
  logic f_oos8, f_clk8, f_oos400, f_clk400;

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; mode_400 = m; slot_valid = 1'b0; mark_p = 1'b0; mark_n = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    last_pol = 1'b0;
  endtask

  // Starts and ends at a falling edge: one slot cycle plus one idle cycle
  task automatic slot(input int k);
    logic p;
    p = (k == K_REP) ? last_pol : ~last_pol;
    if (k == K_NONE) begin
      mark_p = 1'b0; mark_n = 1'b0;
    end else begin
      mark_p = p; mark_n = ~p; last_pol = p;
    end
    slot_valid = 1'b1;
    @(negedge clk);
    s_miss = miss_o; s_oos8 = oos8k_o; s_clk8 = clk8k_o;
    slot_valid = 1'b0; mark_p = 1'b0; mark_n = 1'b0;
    @(negedge clk);
    s_miss_next = miss_o; s_oos8_idle = oos8k_o; s_clk8_idle = clk8k_o;
    s_oos400_idle = oos400_o; s_clk400_idle = clk400_o;
  endtask

  task automatic frame(input int first);
    slot(first);
    f_oos8 = s_oos8_idle; f_clk8 = s_clk8_idle;
    f_oos400 = s_oos400_idle; f_clk400 = s_clk400_idle;
    repeat (7) slot(K_ALT);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    @(negedge clk);
    check("R1 oos8k", oos8k_o, 1'b1);
    check("R1 oos400", oos400_o, 1'b1);
    check("R1 clk8k", clk8k_o, 1'b0);
    check("R1 clk400", clk400_o, 1'b0);
    check("R1 miss", miss_o, 1'b0);

    // Vector table: hunt, lock, 8 kHz duty, missing mark
    do_reset(1'b0);
    for (int i = 0; i < 25; i++) begin
      slot(int'(VEC[i][4:3]));
      check($sformatf("R4 oos8k slot %0d", i), s_oos8, VEC[i][2]);
      check($sformatf("R5 clk8k slot %0d", i), s_clk8, VEC[i][1]);
      check($sformatf("R2 miss slot %0d", i), s_miss, VEC[i][0]);
      check($sformatf("R2 miss one cycle slot %0d", i), s_miss_next, 1'b0);
      check($sformatf("R12 oos8k idle slot %0d", i), s_oos8_idle, s_oos8);
      check($sformatf("R12 clk8k idle slot %0d", i), s_clk8_idle, s_clk8);
    end

    // R3 same-polarity violation 8 slots after a valid one must not lock
    do_reset(1'b0);
    slot(K_ALT); slot(K_REP);
    repeat (6) slot(K_ALT);
    slot(K_NONE);
    slot(K_REP);
    check("R3 invalid violation no lock", s_oos8_idle, 1'b1);

    // Three-tier run: R8 R9 R10 and single-miss tolerance R6
    do_reset(1'b1);
    slot(K_ALT);
    for (int f = 0; f <= 140; f++) begin
      frame((f == 19 || f == 39 || f == 59 || f == 99) ? K_ALT : K_REP);
      case (f)
        19: begin check("R8 first omission no lock", f_oos400, 1'b1);
                  check("R6 omission frame keeps lock", f_oos8, 1'b0); end
        20: check("R6 lock kept after one miss", f_oos8, 1'b0);
        39: begin check("R8 lock at 20-frame spacing", f_oos400, 1'b0);
                  check("R9 clk400 rises", f_clk400, 1'b1); end
        48: check("R9 clk400 high frame 9", f_clk400, 1'b1);
        49: check("R9 clk400 low frame 10", f_clk400, 1'b0);
        59: check("R9 clk400 rises again", f_clk400, 1'b1);
        79: begin check("R10 absent omission flags", f_oos400, 1'b1);
                  check("R10 8k still locked", f_oos8, 1'b0); end
        80: check("R10 flag holds", f_oos400, 1'b1);
        99: check("R10 flag clears", f_oos400, 1'b0);
        119: check("R10 first failure flags", f_oos400, 1'b1);
        139: begin check("R10 second failure unlocks", f_oos400, 1'b1);
                   check("R10 clk400 low", f_clk400, 1'b0); end
        140: check("R10 stays unlocked", f_oos400, 1'b1);
        default: ;
      endcase
    end

    // R7 two-tier mode ignores omissions
    do_reset(1'b0);
    slot(K_ALT);
    for (int f = 0; f <= 40; f++) begin
      frame((f == 19 || f == 39) ? K_ALT : K_REP);
      if (f == 39) begin
        check("R7 oos400 held", f_oos400, 1'b1);
        check("R7 clk400 held", f_clk400, 1'b0);
        check("R7 8k locked", f_oos8, 1'b0);
      end
    end

    // R6 loss after two misses, R11 400 Hz follows
    do_reset(1'b1);
    slot(K_ALT);
    for (int f = 0; f <= 42; f++) begin
      frame((f == 19 || f == 39 || f == 41 || f == 42) ? K_ALT : K_REP);
      if (f == 41) begin
        check("R6 one miss tolerated", f_oos8, 1'b0);
        check("R11 400 still locked", f_oos400, 1'b0);
      end
      if (f == 42) begin
        check("R6 two misses unlock", f_oos8, 1'b1);
        check("R5 clk8k low out of sync", f_clk8, 1'b0);
        check("R11 oos400 follows", f_oos400, 1'b1);
        check("R11 clk400 low", f_clk400, 1'b0);
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule